// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached peripheral with three 8-bit parallel ports (A, B, C) and one write-only command location. An active-low chip select, read strobe and write strobe, together with a 2-bit location address, give a host access to the ports and to the command location. Port C is split into two nibbles. Group A is port A plus the upper nibble of C. Group B is port B plus the lower nibble of C.

Writing the command location with bit 7 set defines the mode and direction of both groups. Writing it with bit 7 clear sets or clears one port C bit. In mode 0 an input port passes its pins straight to the read bus. An output port drives a latched byte that holds until the next write. Handshake behaviour of the higher modes is not built. Their mode codes are still stored, reported on dedicated outputs, and used to enable the single-bit command. Each pin has its own output enable, so the surrounding pad logic can apply the direction.

Top module: `par_port_unit`

## Requirements
- R1: With `cs_ni` high, a write changes no latch and no configuration, and `rdata_oe_o` stays low whatever `rd_ni` is.
- R2: The location address maps 0 to port A, 1 to port B, 2 to port C and 3 to the command location. A read of location 3 returns 0x00.
- R3: A command write with bit 7 = 1 loads the directions: bit 4 sets port A, bit 3 sets upper C, bit 1 sets port B and bit 0 sets lower C, with 1 meaning input. The matching output enables are all high for output and all low for input.
- R4: A command write with bit 7 = 1 clears all three output latches to 0x00 at the same edge.
- R5: A command write with bit 7 = 0 writes the value in bit 0 into port C bit number bits 3:1, and ignores bits 6:4. It acts only while group A's mode is not 0 or group B's mode is 1.
- R6: When both groups are in mode 0, a command write with bit 7 = 0 leaves every latch and all configuration unchanged.
- R7: Group A's mode is taken from command bits 6:5 and reported on `grp_a_mode_o` as 0 for 00, 1 for 01 and 2 for 1x. Group B's mode is command bit 2, reported on `grp_b_mode_o`.
- R8: A read of a port, or port C nibble, that is set as input returns the live pin values.
- R9: A write to a port location loads its latch. The latch drives the port outputs and is held until the next write or clear. A read of an output-configured port returns the latch.
- R10: `rdata_oe_o` is high exactly when `cs_ni` and `rd_ni` are both low. While it is low, `rdata_o` is 0x00.
- R11: While `rst_ni` is low, every port is a mode-0 input, both mode outputs are 0, and every latch is 0x00.
- R12: A write takes effect at the rising clock edge where `cs_ni` and `wr_ni` are both low. A read in that same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Location select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rdata_oe_o | output | 1 | Read data bus drive enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A per-pin output enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B per-pin output enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 8 | Port C per-pin output enable |
| grp_a_mode_o | output | 2 | Group A mode (0, 1, 2) |
| grp_b_mode_o | output | 1 | Group B mode (0, 1) |

## Verification
A read and a write can fall in the same cycle. This is either one access with both strobes low, or a read of a port whose latch is being written at that edge. The bench provokes both by holding both strobes low on the same location. It expects the read bus to show the old latch in that cycle and the new one in the next. A mode definition and its latch clear also land on one edge. The bench checks that latches and direction enables change together and are compared against the reference model on every clock.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PW = 8;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CMD = 2'b11
  } sel_e;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       ch_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RST = '{a_mode: 2'd0, a_in: 1'b1, ch_in: 1'b1,
                               b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_cmd_dec.sv
module ppi_cmd_dec
  import ppi_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [W-1:0]  cmd_i,
  output cfg_t          cfg_o,
  output logic          clr_o,
  output logic          bit_we_o,
  output logic [IW-1:0] bit_idx_o,
  output logic          bit_val_o
);
  localparam int MSB = W - 1;

  cfg_t cfg_q;
  logic is_mdef;
  logic hs_mode;

  assign is_mdef = cmd_i[MSB];
  assign hs_mode = (cfg_q.a_mode != 2'd0) || cfg_q.b_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (cmd_we_i && is_mdef) begin
      // codes 10 and 11 both select mode 2
      cfg_q.a_mode <= cmd_i[6] ? 2'd2 : {1'b0, cmd_i[5]};
      cfg_q.a_in   <= cmd_i[4];
      cfg_q.ch_in  <= cmd_i[3];
      cfg_q.b_mode <= cmd_i[2];
      cfg_q.b_in   <= cmd_i[1];
      cfg_q.cl_in  <= cmd_i[0];
    end
  end

  assign cfg_o     = cfg_q;
  assign clr_o     = cmd_we_i && is_mdef;
  assign bit_we_o  = cmd_we_i && !is_mdef && hs_mode;
  assign bit_idx_o = cmd_i[IW:1];
  assign bit_val_o = cmd_i[0];
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [W-1:0]  d_i,
  input  logic          bit_we_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          bit_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_q;
    if (clr_i) begin
      q_d = '0;
    end else if (we_i) begin
      q_d = d_i;
    end else if (bit_we_i) begin
      q_d[bit_idx_i] = bit_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ppi_rd_mux.sv
module ppi_rd_mux
  import ppi_pkg::*;
#(
  parameter int W = 8,
  localparam int H = W / 2
) (
  input  logic         cs_ni,
  input  logic         rd_ni,
  input  logic [1:0]   addr_i,
  input  cfg_t         cfg_i,
  input  logic [W-1:0] pa_i,
  input  logic [W-1:0] pb_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] la_i,
  input  logic [W-1:0] lb_i,
  input  logic [W-1:0] lc_i,
  output logic [W-1:0] rdata_o,
  output logic         oe_o
);
  logic         rd_act;
  logic [W-1:0] sel_val;

  assign rd_act = !cs_ni && !rd_ni;

  always_comb begin
    unique case (sel_e'(addr_i))
      SEL_A:   sel_val = cfg_i.a_in ? pa_i : la_i;
      SEL_B:   sel_val = cfg_i.b_in ? pb_i : lb_i;
      SEL_C:   sel_val = {cfg_i.ch_in ? pc_i[W-1:H] : lc_i[W-1:H],
                          cfg_i.cl_in ? pc_i[H-1:0] : lc_i[H-1:0]};
      default: sel_val = '0;
    endcase
  end

  assign rdata_o = rd_act ? sel_val : '0;
  assign oe_o    = rd_act;
endmodule

// File: rtl/par_port_unit.sv
module par_port_unit
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] rdata_o,
  output logic          rdata_oe_o,
  input  logic [PW-1:0] pa_i,
  output logic [PW-1:0] pa_o,
  output logic [PW-1:0] pa_oe_o,
  input  logic [PW-1:0] pb_i,
  output logic [PW-1:0] pb_o,
  output logic [PW-1:0] pb_oe_o,
  input  logic [PW-1:0] pc_i,
  output logic [PW-1:0] pc_o,
  output logic [PW-1:0] pc_oe_o,
  output logic [1:0]    grp_a_mode_o,
  output logic          grp_b_mode_o
);
  localparam int NP = 3;
  localparam int H  = PW / 2;
  localparam int IW = $clog2(PW);

  cfg_t          cfg;
  logic          wr_act;
  logic          clr;
  logic          bit_we;
  logic [IW-1:0] bit_idx;
  logic          bit_val;
  logic [PW-1:0] lat [NP];

  assign wr_act = !cs_ni && !wr_ni;

  ppi_cmd_dec #(.W(PW)) i_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (wr_act && (addr_i == SEL_CMD)),
    .cmd_i     (wdata_i),
    .cfg_o     (cfg),
    .clr_o     (clr),
    .bit_we_o  (bit_we),
    .bit_idx_o (bit_idx),
    .bit_val_o (bit_val)
  );

  for (genvar k = 0; k < NP; k++) begin : g_port
    ppi_latch #(.W(PW)) i_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .we_i      (wr_act && (addr_i == 2'(k))),
      .d_i       (wdata_i),
      .bit_we_i  ((k == NP - 1) ? bit_we : 1'b0),
      .bit_idx_i (bit_idx),
      .bit_val_i (bit_val),
      .q_o       (lat[k])
    );
  end

  ppi_rd_mux #(.W(PW)) i_rd (
    .cs_ni   (cs_ni),
    .rd_ni   (rd_ni),
    .addr_i  (addr_i),
    .cfg_i   (cfg),
    .pa_i    (pa_i),
    .pb_i    (pb_i),
    .pc_i    (pc_i),
    .la_i    (lat[0]),
    .lb_i    (lat[1]),
    .lc_i    (lat[2]),
    .rdata_o (rdata_o),
    .oe_o    (rdata_oe_o)
  );

  assign pa_o         = lat[0];
  assign pb_o         = lat[1];
  assign pc_o         = lat[2];
  assign pa_oe_o      = {PW{~cfg.a_in}};
  assign pb_oe_o      = {PW{~cfg.b_in}};
  assign pc_oe_o      = {{H{~cfg.ch_in}}, {H{~cfg.cl_in}}};
  assign grp_a_mode_o = cfg.a_mode;
  assign grp_b_mode_o = cfg.b_mode;
endmodule

// File: rtl/ppi_chk.sv
module ppi_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       rd_ni,
  input logic       wr_ni,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       rdata_oe_o,
  input logic [7:0] pa_i,
  input logic [7:0] pa_o,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pb_i,
  input logic [7:0] pb_o,
  input logic [7:0] pb_oe_o,
  input logic [7:0] pc_i,
  input logic [7:0] pc_o,
  input logic [7:0] pc_oe_o,
  input logic [1:0] grp_a_mode_o,
  input logic       grp_b_mode_o
);
  logic cmd_wr;
  assign cmd_wr = !cs_ni && !wr_ni && (addr_i == 2'b11);

  AST_UNSEL_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pc_oe_o)
              && $stable(pa_oe_o) && $stable(grp_a_mode_o)); // R1

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == 8'h00)); // R10

  AST_CMD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o && addr_i == 2'b11) |-> (rdata_o == 8'h00)); // R2

  AST_MDEF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[7]) |=> (pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00)); // R4

  AST_BSR_IGNORED_MODE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !wdata_i[7] && grp_a_mode_o == 2'd0 && !grp_b_mode_o)
      |=> $stable(pc_o) && $stable(grp_a_mode_o)); // R6

  AST_A_WRITE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !wr_ni && addr_i == 2'b00) |=> (pa_o == $past(wdata_i))); // R9

  AST_A_MODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_a_mode_o != 2'd3); // R7

  AST_NIBBLE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(pc_oe_o[7:4]) inside {0, 4}) && ($countones(pa_oe_o) inside {0, 8})); // R3
endmodule

bind par_port_unit ppi_chk i_chk (.*);

// File: tb/test_par_port_unit.sv
module test_par_port_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr_i = 2'b00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
  logic [7:0] rdata_o, pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;
  logic       rdata_oe_o, grp_b_mode_o;
  logic [1:0] grp_a_mode_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int         m_amode, m_bmode;
  bit         m_ain, m_chin, m_bin, m_clin;
  logic [7:0] m_la, m_lb, m_lc;

  always #10 clk_i = ~clk_i;

  par_port_unit i_par_port_unit (.*);

  task automatic m_reset();
    m_amode = 0; m_bmode = 0;
    m_ain = 1; m_chin = 1; m_bin = 1; m_clin = 1;
    m_la = 0; m_lb = 0; m_lc = 0;
  endtask

  task automatic m_edge();
    if (!cs_ni && !wr_ni) begin
      case (addr_i)
        2'd0: m_la = wdata_i;
        2'd1: m_lb = wdata_i;
        2'd2: m_lc = wdata_i;
        default: begin
          if (wdata_i[7]) begin
            m_amode = wdata_i[6] ? 2 : int'(wdata_i[5]);
            m_ain = wdata_i[4]; m_chin = wdata_i[3];
            m_bmode = int'(wdata_i[2]);
            m_bin = wdata_i[1]; m_clin = wdata_i[0];
            m_la = 0; m_lb = 0; m_lc = 0;
          end else if (m_amode != 0 || m_bmode != 0) begin
            m_lc[wdata_i[3:1]] = wdata_i[0];
          end
        end
      endcase
    end
  endtask

  function automatic logic [7:0] m_read();
    if (cs_ni || rd_ni) return 8'h00;
    case (addr_i)
      2'd0: return m_ain ? pa_i : m_la;
      2'd1: return m_bin ? pb_i : m_lb;
      2'd2: return {m_chin ? pc_i[7:4] : m_lc[7:4], m_clin ? pc_i[3:0] : m_lc[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, "/R10 rdata_oe"}, 16'(rdata_oe_o), 16'(!cs_ni && !rd_ni));
    chk({tag, "/R8 rdata"}, 16'(rdata_o), 16'(m_read()));
    chk({tag, "/R9 port A"}, {pa_o, pa_oe_o}, {m_la, {8{~m_ain}}});
    chk({tag, "/R9 port B"}, {pb_o, pb_oe_o}, {m_lb, {8{~m_bin}}});
    chk({tag, "/R3 port C"}, {pc_o, pc_oe_o}, {m_lc, {4{~m_chin}}, {4{~m_clin}}});
    chk({tag, "/R7 modes"}, {13'd0, grp_a_mode_o, grp_b_mode_o}, 16'({m_amode[1:0], m_bmode[0]}));
  endtask

  // one bus cycle: drive at negedge, compare, model edge, return at next negedge
  task automatic bus(bit cs, bit rd, bit wr, logic [1:0] a, logic [7:0] d, string tag);
    cs_ni = cs; rd_ni = rd; wr_ni = wr; addr_i = a; wdata_i = d;
    #2;
    compare(tag);
    @(posedge clk_i);
    m_edge();
    @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
    bus(0, 1, 0, a, d, tag);
  endtask

  task automatic rd(logic [1:0] a, string tag);
    bus(0, 0, 1, a, 8'h00, tag);
  endtask

  task automatic idle(string tag);
    bus(1, 1, 1, 2'b00, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_reset();
    pa_i = 8'h3C; pb_i = 8'hA5; pc_i = 8'h7E;
    repeat (2) @(negedge clk_i);
    #2; compare("R11 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle("R11 after reset");

    // R2 R8: inputs read live pins, command reads zero
    rd(2'd0, "R2 R8 read A");
    rd(2'd1, "R2 R8 read B");
    pc_i = 8'h81;
    rd(2'd2, "R2 R8 read C");
    rd(2'd3, "R2 read cmd");

    // R1: deselected accesses
    bus(1, 0, 1, 2'd0, 8'h00, "R1 read unselected");
    bus(1, 1, 0, 2'd3, 8'h80, "R1 cmd write unselected");
    bus(1, 1, 0, 2'd0, 8'hFF, "R1 port write unselected");
    idle("R1 after");

    // R3 all outputs, R9 latches
    wr(2'd3, 8'h80, "R3 all outputs");
    wr(2'd0, 8'h5A, "R9 write A");
    wr(2'd1, 8'hC3, "R9 write B");
    wr(2'd2, 8'h96, "R9 write C");
    rd(2'd0, "R9 readback A");
    rd(2'd1, "R9 readback B");
    rd(2'd2, "R9 readback C");
    idle("R9 hold");
    idle("R9 hold 2");

    // R12: read and write same cycle
    bus(0, 0, 0, 2'd0, 8'h11, "R12 rd+wr same cycle");
    rd(2'd0, "R12 next cycle");

    // R6: bit command in mode 0
    wr(2'd3, 8'h0F, "R6 bsr mode0 set");
    wr(2'd3, 8'h04, "R6 bsr mode0 clr");
    rd(2'd2, "R6 port C unchanged");

    // R4 R7 R5: group A mode 1
    wr(2'd3, 8'hA0, "R4 R7 mdef A mode1");
    idle("R4 latches cleared");
    wr(2'd3, 8'h0F, "R5 set C7");
    wr(2'd3, 8'h71, "R5 set C0 dont-care bits");
    wr(2'd3, 8'h05, "R5 set C2");
    wr(2'd3, 8'h04, "R5 clr C2");
    rd(2'd2, "R5 readback C");
    wr(2'd3, 8'h0E, "R5 clr C7");
    idle("R5 after");

    // R7: mode encodings
    wr(2'd3, 8'hE0, "R7 A code 11");
    wr(2'd3, 8'hC4, "R7 A mode2 B mode1");
    wr(2'd3, 8'h84, "R7 B mode1 only");
    wr(2'd3, 8'h07, "R5 bsr via group B");
    idle("R5 group B result");

    // R3 R8: mixed directions
    wr(2'd3, 8'h8A, "R3 mixed dirs");
    wr(2'd0, 8'hF0, "R9 A out");
    wr(2'd2, 8'h3C, "R9 C latch");
    pb_i = 8'h5B; pc_i = 8'hD2;
    rd(2'd1, "R8 B input");
    rd(2'd2, "R8 C mixed nibbles");
    wr(2'd3, 8'h91, "R3 A in, lower C in");
    pa_i = 8'h66;
    rd(2'd0, "R8 A input");
    rd(2'd2, "R8 C lower input");

    // mixed traffic
    for (int i = 0; i < 60; i++) begin
      bit [1:0] a = 2'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom);
      pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
      bus(1'($urandom_range(0, 4) == 0), 1'($urandom), 1'($urandom), a, d, "R12 mixed");
    end

    // R11: reset mid-run
    wr(2'd3, 8'hC0, "R11 setup");
    wr(2'd0, 8'hEE, "R11 setup A");
    rst_ni = 1'b0;
    #2;
    m_reset();
    compare("R11 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R11 released");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule